// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a descriptor list in memory on behalf of a hash engine. An accepted start command latches the list base, the expected total byte count and the interrupt enable. The block then reads descriptors one at a time. Each descriptor is two 32-bit words: a length word followed by an address word. Every descriptor becomes one segment (address, length, final marker) on a valid/ready output. A downstream data fetcher and the hash core consume those segments. The walk ends after the descriptor flagged as final has been accepted downstream. It ends early if a descriptor read fails or if the entry limit is reached without a final flag.

The memory read port allows one outstanding read. A request is held until it is accepted, and the response returns on `rd_rsp_valid`, which the block always accepts. Back-pressure on the segment output works as follows: while `seg_valid` is high and `seg_ready` is low, the segment fields stay frozen. No further descriptor read is issued until the current segment has been accepted. On a clean finish the block raises `done` and pulses `digest_go` to allow the digest write. It also reports whether the accumulated length matched the programmed total.

Top module: `sg_walker`

## Requirements
- R1: A start (`cmd_valid` high) is accepted only when the block is idle and `cmd_word` bit 18 is 1. While a walk is running, or when bit 18 is 0, the start has no effect: it does not change the list, the total, the status or the segments. `busy` is high from the edge after an accepted start until the walk ends.
- R2: For entry n, the length word is read from base + 8·n, and then the address word from base + 8·n + 4. Only one read is outstanding at a time. A request is held with a stable address until it is accepted. Entry n+1 is read only after the segment for entry n has been accepted.
- R3: `seg_len` is bits 27:0 of the length word. `seg_addr` is bits 30:0 of the address word. `seg_last` is bit 31 of the length word. All other bits are ignored.
- R4: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` stay unchanged.
- R5: The walk stops once a segment with `seg_last` = 1 has been accepted. One cycle later, `done` rises, `busy` falls and `digest_go` pulses for exactly one cycle.
- R6: Suppose MAX_ENTRIES segments are accepted and none of them is final. The walk then stops with `err_overrun` = 1, `done` = 0 and no `digest_go` pulse. All MAX_ENTRIES segments will already have been issued.
- R7: A read response with `rd_rsp_err` = 1 on either word of a descriptor stops the walk. That descriptor yields no segment, `err_bus` goes to 1, and `done` and `digest_go` stay low.
- R8: At a clean finish, `len_warn` is 1 exactly when the sum of the issued segment lengths differs from the `src_len` latched at start. A mismatch still finishes with `done` = 1.
- R9: `done` is set on a clean finish whatever the state of the interrupt enable. `irq` is high only while `done` is high and `cmd_word` bit 9 was 1 at the accepted start.
- R10: After reset, all outputs are 0. An accepted start clears `done`, `err_bus`, `err_overrun`, `len_warn` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start strobe |
| cmd_word | input | 32 | Command; bit 18 selects list mode, bit 9 enables irq |
| list_base | input | 32 | Byte address of entry 0 |
| src_len | input | 32 | Expected total byte count |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_addr | output | 32 | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data |
| rd_rsp_err | input | 1 | Read failed |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Downstream takes segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| seg_last | output | 1 | Segment is the final one |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished cleanly (sticky) |
| err_bus | output | 1 | Aborted on read error (sticky) |
| err_overrun | output | 1 | Aborted on entry limit (sticky) |
| len_warn | output | 1 | Total length mismatch (sticky) |
| irq | output | 1 | Completion interrupt |
| digest_go | output | 1 | One-cycle permission to write the digest |

## Verification
A corrupted entry index or base shows up as a wrong read address on the very next request. Since the memory model serves data by address, this turns into a wrong segment within two cycles. A broken length accumulator or latched total is visible only at the end of the walk, as a wrong `len_warn`. A state machine that loses track of the final flag or the entry count shows up as a missing or extra `digest_go`, or as the wrong error flag, once the list runs out. Segment fields that change under back-pressure appear at the stalled port in the next cycle.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_LEN,
    S_WAIT_LEN,
    S_REQ_ADR,
    S_WAIT_ADR,
    S_SEG,
    S_FIN
  } walk_st_t;

  localparam int CMD_LIST_BIT  = 18;
  localparam int CMD_IRQ_BIT   = 9;
  localparam int FINAL_BIT     = 31;
  localparam int ENTRY_BYTES   = 8;
  localparam int ADDR_WORD_OFS = 4;
  localparam int WORD_W        = 32;
endpackage

// File: rtl/sgw_seq.sv
module sgw_seq
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] list_base,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  output logic              cap_len,
  output logic              cap_adr,
  output logic              seg_valid,
  input  logic              seg_ready,
  input  logic              seg_last,
  output logic              acc_clr,
  output logic              acc_add,
  input  logic              len_mismatch,
  output logic              busy,
  output logic              done,
  output logic              err_bus,
  output logic              err_overrun,
  output logic              len_warn,
  output logic              irq,
  output logic              digest_go
);
  walk_st_t          state;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] base_q;
  logic              irq_en_q;
  logic              start_acc;
  logic              at_limit;
  logic [WORD_W-1:0] entry_ofs;
  logic              unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_word;

  assign start_acc = cmd_valid && cmd_word[CMD_LIST_BIT] && (state == S_IDLE);
  assign at_limit  = (idx == IDX_W'(MAX_ENTRIES - 1));
  assign entry_ofs = WORD_W'(idx) * WORD_W'(ENTRY_BYTES);

  assign rd_req_valid = (state == S_REQ_LEN) || (state == S_REQ_ADR);
  assign rd_req_addr  = base_q + entry_ofs +
                        ((state == S_REQ_ADR) ? WORD_W'(ADDR_WORD_OFS) : '0);
  assign cap_len   = (state == S_WAIT_LEN) && rd_rsp_valid && !rd_rsp_err;
  assign cap_adr   = (state == S_WAIT_ADR) && rd_rsp_valid && !rd_rsp_err;
  assign seg_valid = (state == S_SEG);
  assign acc_clr   = start_acc;
  assign acc_add   = seg_valid && seg_ready;
  assign busy      = (state != S_IDLE);
  assign irq       = done && irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      base_q      <= '0;
      irq_en_q    <= 1'b0;
      done        <= 1'b0;
      err_bus     <= 1'b0;
      err_overrun <= 1'b0;
      len_warn    <= 1'b0;
      digest_go   <= 1'b0;
    end else begin
      digest_go <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_acc) begin
            state       <= S_REQ_LEN;
            idx         <= '0;
            base_q      <= list_base;
            irq_en_q    <= cmd_word[CMD_IRQ_BIT];
            done        <= 1'b0;
            err_bus     <= 1'b0;
            err_overrun <= 1'b0;
            len_warn    <= 1'b0;
          end
        end
        S_REQ_LEN: if (rd_req_ready) state <= S_WAIT_LEN;
        S_WAIT_LEN: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              state   <= S_IDLE;
              err_bus <= 1'b1;
            end else begin
              state <= S_REQ_ADR;
            end
          end
        end
        S_REQ_ADR: if (rd_req_ready) state <= S_WAIT_ADR;
        S_WAIT_ADR: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              state   <= S_IDLE;
              err_bus <= 1'b1;
            end else begin
              state <= S_SEG;
            end
          end
        end
        S_SEG: begin
          if (seg_ready) begin
            if (seg_last) begin
              state <= S_FIN;
            end else if (at_limit) begin
              state       <= S_IDLE;
              err_overrun <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_REQ_LEN;
            end
          end
        end
        S_FIN: begin
          state     <= S_IDLE;
          done      <= 1'b1;
          digest_go <= 1'b1;
          len_warn  <= len_mismatch;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R1
  busy_status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !err_bus && !err_overrun);

  // R1
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid) && $past(cmd_word[CMD_LIST_BIT]));

  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R5
  go_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_go |-> done && !busy);

  // R5
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_go |=> !digest_go);
endmodule

// File: rtl/sgw_desc.sv
module sgw_desc
  import sgw_pkg::*;
#(
  parameter int LEN_W  = 28,
  parameter int ADDR_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_len,
  input  logic              cap_adr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_len  <= '0;
      seg_last <= 1'b0;
      seg_addr <= '0;
    end else begin
      if (cap_len) begin
        seg_len  <= rd_data[LEN_W-1:0];
        seg_last <= rd_data[FINAL_BIT];
      end
      if (cap_adr) seg_addr <= rd_data[ADDR_W-1:0];
    end
  end

  // R3
  desc_cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_len && cap_adr));
endmodule

// File: rtl/sgw_acc.sv
module sgw_acc
  import sgw_pkg::*;
#(
  parameter int LEN_W = 28,
  parameter int IDX_W = 8,
  localparam int SUM_W = LEN_W + IDX_W,
  localparam int CMP_W = (SUM_W > WORD_W) ? SUM_W : WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] src_len,
  input  logic              add,
  input  logic [LEN_W-1:0]  add_len,
  output logic              mismatch
);
  logic [SUM_W-1:0]  sum_q;
  logic [WORD_W-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      src_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
      src_q <= src_len;
    end else if (add) begin
      sum_q <= sum_q + SUM_W'(add_len);
    end
  end

  assign mismatch = CMP_W'(sum_q) != CMP_W'(src_q);

  // R8
  sum_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> sum_q >= $past(sum_q));
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  parameter int LEN_W       = 28,
  parameter int ADDR_W      = 31,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       list_base,
  input  logic [31:0]       src_len,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              seg_last,
  output logic              busy,
  output logic              done,
  output logic              err_bus,
  output logic              err_overrun,
  output logic              len_warn,
  output logic              irq,
  output logic              digest_go
);
  logic cap_len, cap_adr, acc_clr, acc_add, len_mismatch;

  sgw_seq #(.MAX_ENTRIES(MAX_ENTRIES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .list_base    (list_base),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_err   (rd_rsp_err),
    .cap_len      (cap_len),
    .cap_adr      (cap_adr),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_last     (seg_last),
    .acc_clr      (acc_clr),
    .acc_add      (acc_add),
    .len_mismatch (len_mismatch),
    .busy         (busy),
    .done         (done),
    .err_bus      (err_bus),
    .err_overrun  (err_overrun),
    .len_warn     (len_warn),
    .irq          (irq),
    .digest_go    (digest_go)
  );

  sgw_desc #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_len  (cap_len),
    .cap_adr  (cap_adr),
    .rd_data  (rd_rsp_data),
    .seg_addr (seg_addr),
    .seg_len  (seg_len),
    .seg_last (seg_last)
  );

  sgw_acc #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (acc_clr),
    .src_len  (src_len),
    .add      (acc_add),
    .add_len  (seg_len),
    .mismatch (len_mismatch)
  );

  // R4
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) &&
                                $stable(seg_len) && $stable(seg_last));

  // R2
  seg_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !rd_req_valid && busy);

  // R7
  err_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bus || err_overrun) |-> !done && !digest_go);
endmodule

// File: tb/sim_sg_walker.sv
`timescale 1ns/1ps
module sim_sg_walker;
  localparam int MAXE = 4;
  localparam int LW   = 28;
  localparam int AWD  = 31;
  localparam logic [31:0] BASE  = 32'h100;
  localparam logic [31:0] BASE2 = 32'h200;
  localparam logic [31:0] LIST_CMD = 32'h0004_0000;
  localparam logic [31:0] IRQ_CMD  = 32'h0000_0200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cmd_valid, rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_err;
  logic [31:0] cmd_word, list_base, src_len, rd_req_addr, rd_rsp_data;
  logic seg_valid, seg_last, busy, done, err_bus, err_overrun, len_warn, irq, digest_go;
  logic seg_ready = 1'b1;
  logic [AWD-1:0] seg_addr;
  logic [LW-1:0]  seg_len;

  sg_walker #(.MAX_ENTRIES(MAXE), .LEN_W(LW), .ADDR_W(AWD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .list_base(list_base), .src_len(src_len), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .busy(busy), .done(done),
    .err_bus(err_bus), .err_overrun(err_overrun), .len_warn(len_warn),
    .irq(irq), .digest_go(digest_go)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [LW-1:0]  got_len [0:15];
  logic [AWD-1:0] got_adr [0:15];
  logic           got_last [0:15];
  int got_n = 0, go_cnt = 0;
  logic [LW-1:0]  exp_len [0:MAXE-1];
  logic [AWD-1:0] exp_adr [0:MAXE-1];
  logic [31:0]    exp_sum;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_sim();
  end

  // memory model, segment sink and go counter
  initial begin : env
    bit pend;
    logic [31:0] pa;
    pend = 1'b0;
    pa = '0;
    rd_req_ready = 1'b1;
    rd_rsp_valid = 1'b0;
    rd_rsp_err = 1'b0;
    rd_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[pa[9:2]];
        rd_rsp_err   = (pa == err_addr);
        pend = 1'b0;
      end else begin
        rd_rsp_valid = 1'b0;
        rd_rsp_err   = 1'b0;
      end
      if (rd_req_valid && rd_req_ready) begin
        pend = 1'b1;
        pa = rd_req_addr;
      end
      seg_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (seg_valid && seg_ready && got_n < 16) begin
        got_len[got_n]  = seg_len;
        got_adr[got_n]  = seg_addr;
        got_last[got_n] = seg_last;
        got_n++;
      end
      if (digest_go) go_cnt++;
    end
  end

  task automatic build(int n, bit mark_last, int seed);
    logic [31:0] lw, aw;
    exp_sum = '0;
    for (int i = 0; i < MAXE; i++) begin
      exp_len[i] = LW'((seed * 37 + i * 211 + 5) & 32'hFFFFF);
      exp_adr[i] = AWD'((32'h1234_0000 + i * 32'h0101_0010 + seed * 64) & 32'h7FFF_FFFF);
      lw = {(mark_last && i == n - 1), 3'((i + seed) % 8), exp_len[i]};
      aw = {1'(i % 2), exp_adr[i]};
      mem[BASE[9:2] + 8'(2 * i)]     = lw;
      mem[BASE[9:2] + 8'(2 * i + 1)] = aw;
      if (i < n) exp_sum = exp_sum + 32'(exp_len[i]);
    end
  endtask

  task automatic start(logic [31:0] cmd, logic [31:0] base, logic [31:0] sl);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = cmd;
    list_base = base;
    src_len   = sl;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R1 walk ends", 64'(t < 5000), 64'd1);
    @(negedge clk);
  endtask

  task automatic run_ok(int n, bit ien, bit stl, int delta, bit ign, int seed);
    build(n, 1'b1, seed);
    got_n = 0;
    go_cnt = 0;
    stall = stl;
    start(LIST_CMD | (ien ? IRQ_CMD : 32'h0), BASE, exp_sum + 32'(delta));
    chk("R1 busy after start", 64'(busy), 64'd1);
    if (ign) start(LIST_CMD, BASE2, exp_sum + 32'd99);
    wait_idle();
    chk("R5 segment count", 64'(got_n), 64'(n));
    for (int i = 0; i < n; i++) begin
      chk("R3 seg_len", 64'(got_len[i]), 64'(exp_len[i]));
      chk("R2 R3 seg_addr", 64'(got_adr[i]), 64'(exp_adr[i]));
      chk("R3 seg_last", 64'(got_last[i]), 64'(i == n - 1));
    end
    chk("R5 done", 64'(done), 64'd1);
    chk("R5 digest_go pulses", 64'(go_cnt), 64'd1);
    chk("R6 R7 no error", 64'({err_bus, err_overrun}), 64'd0);
    chk("R8 len_warn", 64'(len_warn), 64'(delta != 0));
    chk("R9 irq", 64'(irq), 64'(ien));
    stall = 1'b0;
  endtask

  initial begin : main
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_word = '0;
    list_base = '0;
    src_len = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs",
        64'({busy, done, err_bus, err_overrun, len_warn, irq, digest_go, seg_valid, rd_req_valid}),
        64'd0);

    // sweep of list length, irq enable, back-pressure and length match (R2 R3 R4 R5 R8 R9)
    for (int n = 1; n <= MAXE; n++)
      for (int ien = 0; ien < 2; ien++)
        for (int stl = 0; stl < 2; stl++)
          for (int d = 0; d < 2; d++)
            run_ok(n, 1'(ien), 1'(stl), d * 3, 1'b0, n * 8 + ien * 4 + stl * 2 + d);

    // R1 second start during a walk is ignored
    run_ok(3, 1'b1, 1'b1, 0, 1'b1, 77);
    run_ok(2, 1'b0, 1'b0, 5, 1'b1, 78);

    // R1 start without list mode bit is ignored; R10 status kept
    got_n = 0;
    start(IRQ_CMD, BASE, 32'd0);
    repeat (4) @(negedge clk);
    chk("R1 no-list start busy", 64'(busy), 64'd0);
    chk("R1 no-list start keeps done", 64'(done), 64'd1);
    chk("R1 no-list start no segments", 64'(got_n), 64'd0);

    // R6 entry limit without final flag
    for (int stl = 0; stl < 2; stl++) begin
      build(MAXE, 1'b0, 40 + stl);
      got_n = 0;
      go_cnt = 0;
      stall = 1'(stl);
      start(LIST_CMD | IRQ_CMD, BASE, exp_sum);
      chk("R10 start clears done", 64'(done), 64'd0);
      wait_idle();
      chk("R6 segments before overrun", 64'(got_n), 64'(MAXE));
      chk("R6 err_overrun", 64'(err_overrun), 64'd1);
      chk("R6 no done/irq/go", 64'({done, irq, go_cnt != 0}), 64'd0);
      stall = 1'b0;
    end

    // R7 read error on each word of each entry
    for (int k = 0; k < MAXE; k++)
      for (int w = 0; w < 2; w++) begin
        build(MAXE, 1'b1, 60 + k);
        err_addr = BASE + 32'(8 * k + 4 * w);
        got_n = 0;
        go_cnt = 0;
        start(LIST_CMD | IRQ_CMD, BASE, exp_sum);
        wait_idle();
        chk("R7 segments before error", 64'(got_n), 64'(k));
        chk("R7 err_bus", 64'(err_bus), 64'd1);
        chk("R7 no done/irq/go/overrun", 64'({done, irq, err_overrun, go_cnt != 0}), 64'd0);
        err_addr = 32'hFFFF_FFFF;
      end

    // R10 a clean walk after an error clears the error
    run_ok(1, 1'b0, 1'b0, 0, 1'b0, 90);
    finish_sim();
  end
endmodule